// File: doc/BRIEF.md
# Four-Stage Watchdog Timer

This block is a watchdog with four timeout stages in a chain. A prescaler divides the core clock into ticks. The active stage counts ticks up to its own hold value. When it reaches that value, it carries out its configured action and hands over to the next stage. After the last stage, control wraps back to the first. The possible actions are: nothing, a sticky interrupt, a CPU reset pulse, or a system reset pulse. Each reset pulse has a programmable width.

Software reaches the block through a simple word-addressed write bus with a combinational read port. Every register except the key register is locked until the unlock key is written. Stage actions, hold values, the prescaler, the pulse widths and the boot-arm bit are written into shadow copies. They take effect only when a control write also sets the commit bit. The run bit and the boot-arm bit each arm the timer on their own. A write to the feed address restarts the timer at stage 0.

Top module: `wdog_multistage`

## Requirements
- R1: After reset the block is locked. Every readable field reads 0, except the prescaler, which reads 1. All three outputs are low.
- R2: While locked, a write to any address other than the key address (7) changes nothing. This covers control, prescaler, hold, feed and interrupt writes.
- R3: A write of 0x50D83AA1 to address 7 unlocks the block, and a write of any other value to address 7 locks it. Reading address 7 returns the lock state in bit 0, with 1 meaning unlocked.
- R4: Control word (address 0) layout:
  - bit 0: run
  - bit 1: boot-arm
  - bits [2n+3:2n+2]: action of stage n
  - bits [12:10]: CPU pulse code
  - bits [15:13]: system pulse code
  - bit 16: commit

  The prescaler is at address 1, bits [15:0]. The hold value of stage n is at address 2+n. All of these except run go only to shadow copies, and reads return the shadow copies. A control write with bit 16 set copies that write's shadow values to the active set. Run takes effect at once.
- R5: The prescaler makes one tick every P clocks. A stage with hold H times out on its H-th tick. After a feed, the first timeout comes H*P cycles later (a value of 0 for P or H counts as 1).
- R6: Each timeout moves from stage n to stage n+1, and from stage 3 back to stage 0. The count restarts on every change of stage.
- R7: Action codes are 0 none, 1 interrupt, 2 CPU reset, 3 system reset. A stage with code 0 times out silently.
- R8: A write of any data to address 6 clears the tick count and the prescaler phase and returns the timer to stage 0.
- R9: Pulse width codes 0 to 7 select 100, 200, 300, 400, 500, 800, 1600 and 3200 ns. The output stays high for ceil(ns / CLK_PERIOD_NS) cycles, and a new trigger reloads the width.
- R10: The timer runs when run or the active boot-arm bit is 1. With both at 0 it is held at stage 0 with zero count.
- R11: The interrupt status (read at address 9, bit 0) sets on an interrupt timeout and stays set. A write of 1 to bit 0 of address 10 clears it; a set in the same cycle wins. The interrupt output is status AND enable, where enable is bit 0 of address 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Watchdog interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest thing to reach from the ports is the stage sequence and its wrap. The current stage is not visible, so the order can only be inferred from when actions appear. The bench makes the first three stages silent and gives every stage a distinct hold. A reset action on stage 3 then has a first-arrival time and a repeat period that both equal the sum of the holds, which proves the order and the return to stage 0. Pulse widths are measured over windows long enough to hold exactly one CPU pulse and one system pulse. A behavioural model runs alongside and compares the three outputs on every cycle, which covers shadow commits and feeds landing at arbitrary prescaler phases.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NSTG    = 4;
  localparam int HOLD_W  = 32;
  localparam int PRESC_W = 16;
  localparam int LEN_W   = 3;
  localparam int ACT_W   = 2;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = $clog2(NSTG);

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h50D8_3AA1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
  localparam logic [ADDR_W-1:0] A_HOLD0 = 4'd2;
  localparam logic [ADDR_W-1:0] A_FEED  = 4'd6;
  localparam logic [ADDR_W-1:0] A_KEY   = 4'd7;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd8;
  localparam logic [ADDR_W-1:0] A_ISTAT = 4'd9;
  localparam logic [ADDR_W-1:0] A_ICLR  = 4'd10;

  localparam int B_RUN    = 0;
  localparam int B_BOOT   = 1;
  localparam int B_ACT    = 2;
  localparam int B_CPULEN = B_ACT + NSTG*ACT_W;
  localparam int B_SYSLEN = B_CPULEN + LEN_W;
  localparam int B_COMMIT = B_SYSLEN + LEN_W;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } act_e;

  typedef struct packed {
    logic                            boot_en;
    logic [NSTG-1:0][ACT_W-1:0]      act;
    logic [LEN_W-1:0]                cpu_len;
    logic [LEN_W-1:0]                sys_len;
    logic [PRESC_W-1:0]              presc;
    logic [NSTG-1:0][HOLD_W-1:0]     hold;
  } wd_cfg_t;

  function automatic int unsigned code_to_ns(input logic [LEN_W-1:0] code);
    case (code)
      3'd0:    return 100;
      3'd1:    return 200;
      3'd2:    return 300;
      3'd3:    return 400;
      3'd4:    return 500;
      3'd5:    return 800;
      3'd6:    return 1600;
      default: return 3200;
    endcase
  endfunction

  function automatic int unsigned code_to_cycles(input logic [LEN_W-1:0] code,
                                                 input int unsigned clk_ns);
    int unsigned c;
    c = (code_to_ns(code) + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              set_irq,
  output logic [DATA_W-1:0] bus_rdata,
  output wd_cfg_t           cfg_act,
  output logic              run_en,
  output logic              feed_stb,
  output logic              irq_en,
  output logic              irq_stat,
  output logic              unlocked
);
  wd_cfg_t shadow_q, shadow_d;
  wd_cfg_t active_q, active_d;
  logic    unl_q, unl_d;
  logic    run_q, run_d;
  logic    ien_q, ien_d;
  logic    ist_q, ist_d;
  logic    wr_ok, commit, clr_req;

  assign wr_ok   = bus_wr & unl_q;
  assign clr_req = wr_ok & (bus_addr == A_ICLR) & bus_wdata[0];

  always_comb begin
    shadow_d = shadow_q;
    run_d    = run_q;
    ien_d    = ien_q;
    commit   = 1'b0;
    if (wr_ok) begin
      case (bus_addr)
        A_CTRL: begin
          run_d            = bus_wdata[B_RUN];
          shadow_d.boot_en = bus_wdata[B_BOOT];
          shadow_d.act     = bus_wdata[B_CPULEN-1:B_ACT];
          shadow_d.cpu_len = bus_wdata[B_SYSLEN-1:B_CPULEN];
          shadow_d.sys_len = bus_wdata[B_COMMIT-1:B_SYSLEN];
          commit           = bus_wdata[B_COMMIT];
        end
        A_PRESC: shadow_d.presc = bus_wdata[PRESC_W-1:0];
        A_IEN:   ien_d = bus_wdata[0];
        default: ;
      endcase
      for (int i = 0; i < NSTG; i++) begin
        if (bus_addr == ADDR_W'(int'(A_HOLD0) + i))
          shadow_d.hold[i] = bus_wdata[HOLD_W-1:0];
      end
    end
  end

  always_comb begin
    active_d = commit ? shadow_d : active_q;
    unl_d    = unl_q;
    if (bus_wr && (bus_addr == A_KEY))
      unl_d = (bus_wdata == UNLOCK_KEY);
    ist_d = ist_q;
    if (set_irq)
      ist_d = 1'b1;
    else if (clr_req)
      ist_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q       <= '0;
      shadow_q.presc <= PRESC_W'(1);
      active_q       <= '0;
      active_q.presc <= PRESC_W'(1);
      unl_q          <= 1'b0;
      run_q          <= 1'b0;
      ien_q          <= 1'b0;
      ist_q          <= 1'b0;
    end else begin
      if (wr_ok)
        shadow_q <= shadow_d;
      if (commit)
        active_q <= active_d;
      unl_q <= unl_d;
      if (wr_ok)
        run_q <= run_d;
      if (wr_ok)
        ien_q <= ien_d;
      ist_q <= ist_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_RUN]                 = run_q;
        bus_rdata[B_BOOT]                = shadow_q.boot_en;
        bus_rdata[B_CPULEN-1:B_ACT]      = shadow_q.act;
        bus_rdata[B_SYSLEN-1:B_CPULEN]   = shadow_q.cpu_len;
        bus_rdata[B_COMMIT-1:B_SYSLEN]   = shadow_q.sys_len;
      end
      A_PRESC: bus_rdata[PRESC_W-1:0] = shadow_q.presc;
      A_KEY:   bus_rdata[0] = unl_q;
      A_IEN:   bus_rdata[0] = ien_q;
      A_ISTAT: bus_rdata[0] = ist_q;
      default: ;
    endcase
    for (int i = 0; i < NSTG; i++) begin
      if (bus_addr == ADDR_W'(int'(A_HOLD0) + i))
        bus_rdata[HOLD_W-1:0] = shadow_q.hold[i];
    end
  end

  assign cfg_act  = active_q;
  assign run_en   = run_q;
  assign feed_stb = wr_ok & (bus_addr == A_FEED);
  assign irq_en   = ien_q;
  assign irq_stat = ist_q;
  assign unlocked = unl_q;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] div_q, div_d;
  logic [PRESC_W-1:0] presc_eff;
  logic               last;

  assign presc_eff = (presc == '0) ? PRESC_W'(1) : presc;
  assign last      = (div_q >= (presc_eff - PRESC_W'(1)));
  assign tick      = ~clr & last;

  always_comb begin
    if (clr)
      div_d = '0;
    else if (last)
      div_d = '0;
    else
      div_d = div_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= '0;
    else
      div_q <= div_d;
  end
endmodule

// File: rtl/wdog_stager.sv
module wdog_stager
  import wdog_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        tick,
  input  logic [NSTG-1:0][ACT_W-1:0]  act,
  input  logic [NSTG-1:0][HOLD_W-1:0] hold,
  output logic [SEL_W-1:0]            stage,
  output logic                        fire,
  output logic [ACT_W-1:0]            fire_act
);
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0]  stg_q, stg_d;
  logic [HOLD_W-1:0] hold_sel, hold_eff;
  logic              done;

  assign hold_sel = hold[stg_q];
  assign hold_eff = (hold_sel == '0) ? HOLD_W'(1) : hold_sel;
  assign done     = ({1'b0, cnt_q} + (HOLD_W+1)'(1)) >= {1'b0, hold_eff};
  assign fire     = tick & done;
  assign fire_act = act[stg_q];

  always_comb begin
    cnt_d = cnt_q;
    stg_d = stg_q;
    if (clr) begin
      cnt_d = '0;
      stg_d = '0;
    end else if (tick) begin
      if (done) begin
        cnt_d = '0;
        stg_d = (stg_q == SEL_W'(NSTG-1)) ? '0 : stg_q + SEL_W'(1);
      end else begin
        cnt_d = cnt_q + HOLD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      stg_q <= stg_d;
    end
  end

  assign stage = stg_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [LEN_W-1:0] code,
  output logic             pulse
);
  localparam int unsigned MAXC = code_to_cycles(3'd7, CLK_PERIOD_NS);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] load;

  assign load = CW'(code_to_cycles(code, CLK_PERIOD_NS));

  always_comb begin
    if (trig)
      cnt_d = load;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign pulse = (cnt_q != '0);
endmodule

// File: rtl/wdog_multistage.sv
module wdog_multistage
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  wd_cfg_t          cfg;
  logic             run_en, feed_stb, irq_en, irq_stat, unlocked;
  logic             armed, clr, tick, fire;
  logic [SEL_W-1:0] cur_stage;
  logic [ACT_W-1:0] fire_act;
  logic             set_irq;
  logic [1:0]       p_trig;
  logic [1:0][LEN_W-1:0] p_code;
  logic [1:0]       p_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdog_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .set_irq   (set_irq),
    .bus_rdata (bus_rdata),
    .cfg_act   (cfg),
    .run_en    (run_en),
    .feed_stb  (feed_stb),
    .irq_en    (irq_en),
    .irq_stat  (irq_stat),
    .unlocked  (unlocked)
  );

  assign armed = run_en | cfg.boot_en;
  assign clr   = feed_stb | ~armed;

  wdog_prescale u_presc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (clr),
    .presc (cfg.presc),
    .tick  (tick)
  );

  wdog_stager u_stager (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (clr),
    .tick     (tick),
    .act      (cfg.act),
    .hold     (cfg.hold),
    .stage    (cur_stage),
    .fire     (fire),
    .fire_act (fire_act)
  );

  assign set_irq   = fire & (fire_act == ACT_IRQ);
  assign p_trig[0] = fire & (fire_act == ACT_CPU);
  assign p_trig[1] = fire & (fire_act == ACT_SYS);
  assign p_code[0] = cfg.cpu_len;
  assign p_code[1] = cfg.sys_len;

  for (genvar g = 0; g < 2; g++) begin : g_pulse
    wdog_pulse #(.CLK_PERIOD_NS(CLK_PERIOD_NS)) u_pulse (
      .clk   (clk),
      .rst_n (rst_int_n),
      .trig  (p_trig[g]),
      .code  (p_code[g]),
      .pulse (p_out[g])
    );
  end

  assign cpu_rst_o = p_out[0];
  assign sys_rst_o = p_out[1];
  assign irq_o     = irq_stat & irq_en;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              cpu_rst_o,
  input logic [SEL_W-1:0]  stage,
  input logic              fire,
  input logic [ACT_W-1:0]  fire_act,
  input logic              feed,
  input logic              armed,
  input logic              unlocked,
  input logic              irq_stat
);
  logic key_wr, clr_req;
  assign key_wr  = bus_wr && (bus_addr == A_KEY);
  assign clr_req = bus_wr && unlocked && (bus_addr == A_ICLR) && bus_wdata[0];

  p_key_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (unlocked == ($past(bus_wdata) == UNLOCK_KEY)));

  p_stay_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !key_wr) |=> !unlocked);

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (stage == $past(stage) + SEL_W'(1)));

  p_feed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (stage == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (stage == '0));

  p_no_fire_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !fire);

  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_act == ACT_IRQ) |=> irq_stat);

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat && !clr_req) |=> irq_stat);

  p_cpu_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_act == ACT_CPU) |=> cpu_rst_o);
endmodule

bind wdog_multistage wdog_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cpu_rst_o (cpu_rst_o),
  .stage     (cur_stage),
  .fire      (fire),
  .fire_act  (fire_act),
  .feed      (feed_stb),
  .armed     (armed),
  .unlocked  (unlocked),
  .irq_stat  (irq_stat)
);

// File: tb/sim_wdog_multistage.sv
`timescale 1ns/1ps
module sim_wdog_multistage;
  localparam logic [31:0] KEY = 32'h50D8_3AA1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_o, cpu_rst_o, sys_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  wdog_multistage #(.CLK_PERIOD_NS(10)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int code);
    int ns;
    case (code)
      0: ns = 100; 1: ns = 200; 2: ns = 300; 3: ns = 400;
      4: ns = 500; 5: ns = 800; 6: ns = 1600; default: ns = 3200;
    endcase
    return (ns + 9) / 10;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit     m_unl, m_run, m_ien, m_ist;
  int     m_div, m_cnt, m_stg, m_cpu, m_sys;
  int     sh_act[4], ac_act[4];
  longint sh_hold[4], ac_hold[4];
  int     sh_presc, ac_presc, sh_cl, ac_cl, sh_sl, ac_sl;
  bit     sh_boot, ac_boot;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_unl = 0; m_run = 0; m_ien = 0; m_ist = 0;
      m_div = 0; m_cnt = 0; m_stg = 0; m_cpu = 0; m_sys = 0;
      for (int i = 0; i < 4; i++) begin
        sh_act[i] = 0; ac_act[i] = 0; sh_hold[i] = 0; ac_hold[i] = 0;
      end
      sh_presc = 1; ac_presc = 1; sh_cl = 0; ac_cl = 0; sh_sl = 0; ac_sl = 0;
      sh_boot = 0; ac_boot = 0;
    end else begin
      bit ok, feed, armed, fire;
      int fa, pe;
      longint he;
      ok    = bus_wr && m_unl;
      feed  = ok && bus_addr == 4'd6;
      armed = m_run || ac_boot;
      fire  = 0; fa = 0;
      if (feed || !armed) begin
        m_div = 0; m_cnt = 0; m_stg = 0;
      end else begin
        pe = (ac_presc == 0) ? 1 : ac_presc;
        if (m_div >= pe - 1) begin
          m_div = 0;
          he = (ac_hold[m_stg] == 0) ? 1 : ac_hold[m_stg];
          if (m_cnt + 1 >= he) begin
            fire = 1; fa = ac_act[m_stg]; m_cnt = 0; m_stg = (m_stg + 1) % 4;
          end else m_cnt++;
        end else m_div++;
      end
      if (fire && fa == 2) m_cpu = exp_cycles(ac_cl); else if (m_cpu > 0) m_cpu--;
      if (fire && fa == 3) m_sys = exp_cycles(ac_sl); else if (m_sys > 0) m_sys--;
      if (fire && fa == 1) m_ist = 1;
      else if (ok && bus_addr == 4'd10 && bus_wdata[0]) m_ist = 0;
      if (ok) begin
        case (bus_addr)
          4'd0: begin
            m_run = bus_wdata[0]; sh_boot = bus_wdata[1];
            for (int i = 0; i < 4; i++) sh_act[i] = int'(bus_wdata[2+2*i +: 2]);
            sh_cl = int'(bus_wdata[12:10]); sh_sl = int'(bus_wdata[15:13]);
            if (bus_wdata[16]) begin
              ac_boot = sh_boot; ac_cl = sh_cl; ac_sl = sh_sl; ac_presc = sh_presc;
              for (int i = 0; i < 4; i++) begin
                ac_act[i] = sh_act[i]; ac_hold[i] = sh_hold[i];
              end
            end
          end
          4'd1: sh_presc = int'(bus_wdata[15:0]);
          4'd2, 4'd3, 4'd4, 4'd5: sh_hold[bus_addr - 2] = longint'(bus_wdata);
          4'd8: m_ien = bus_wdata[0];
          default: ;
        endcase
      end
      if (bus_wr && bus_addr == 4'd7) m_unl = (bus_wdata == KEY);
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R7 R9 R11 model irq", irq_o, m_ist && m_ien);
      chk("R7 R9 model cpu_rst", cpu_rst_o, m_cpu != 0);
      chk("R7 R9 model sys_rst", sys_rst_o, m_sys != 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk(input int run, boot, a0, a1, a2, a3, cl, sl, cm);
    return 32'(run) | (32'(boot) << 1) | (32'(a0) << 2) | (32'(a1) << 4) |
           (32'(a2) << 6) | (32'(a3) << 8) | (32'(cl) << 10) | (32'(sl) << 13) |
           (32'(cm) << 16);
  endfunction

  task automatic wait_rise_cpu(output int n);
    n = 0;
    while (!cpu_rst_o && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [31:0] d;
    int n, ncpu, nsys;
    int codes_c[2] = '{0, 3};
    int codes_s[2] = '{5, 7};

    repeat (3) @(negedge clk);
    rst_n = 1; model_on = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'd0, d); chk("R1 ctrl reset", d, 0);
    rd(4'd1, d); chk("R1 presc reset", d, 1);
    rd(4'd7, d); chk("R1 locked at reset", d, 0);
    rd(4'd4, d); chk("R1 hold2 reset", d, 0);
    rd(4'd9, d); chk("R1 status reset", d, 0);
    chk("R1 outputs low", {irq_o, cpu_rst_o, sys_rst_o}, 0);

    // R2 locked writes ignored
    wr(4'd0, mk(1, 0, 1, 0, 0, 0, 0, 0, 1));
    rd(4'd0, d); chk("R2 ctrl write while locked", d, 0);
    wr(4'd1, 32'd5);
    rd(4'd1, d); chk("R2 presc write while locked", d, 1);
    repeat (10) @(negedge clk);

    // R3 key
    wr(4'd7, KEY);          rd(4'd7, d); chk("R3 unlock", d, 1);
    wr(4'd7, 32'd0);        rd(4'd7, d); chk("R3 relock with 0", d, 0);
    wr(4'd7, KEY);
    wr(4'd7, KEY ^ 32'd1);  rd(4'd7, d); chk("R3 wrong key locks", d, 0);
    wr(4'd7, KEY);          rd(4'd7, d); chk("R3 unlock again", d, 1);

    // R4 shadow then commit, R5 tick timing
    wr(4'd8, 32'd1);
    wr(4'd2, 32'd3);
    wr(4'd1, 32'd2);
    wr(4'd0, mk(1, 0, 1, 0, 0, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk("R4 uncommitted action inert", irq_o, 0);
    rd(4'd0, d); chk("R4 shadow readback", d, mk(1, 0, 1, 0, 0, 0, 0, 0, 0));
    rd(4'd2, d); chk("R4 hold shadow readback", d, 3);
    wr(4'd0, mk(1, 0, 1, 0, 0, 0, 0, 0, 1));
    wr(4'd6, 32'd0);
    n = 0;
    while (!irq_o && n < 1000) begin @(negedge clk); n++; end
    chk("R5 timeout after hold*presc", n, 6);

    // R11 interrupt gating, status, clear
    wr(4'd8, 32'd0);
    chk("R11 irq gated by enable", irq_o, 0);
    rd(4'd9, d); chk("R11 status sticky", d, 1);
    wr(4'd10, 32'd1);
    rd(4'd9, d); chk("R11 status cleared", d, 0);
    wr(4'd8, 32'd1);
    repeat (30) @(negedge clk);
    chk("R11 status set again", irq_o, 1);
    wr(4'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 1));
    wr(4'd10, 32'd1);

    // R9 pulse widths
    wr(4'd2, 32'd2); wr(4'd3, 32'd3); wr(4'd4, 32'd1000); wr(4'd5, 32'd1000);
    wr(4'd1, 32'd1);
    for (int k = 0; k < 2; k++) begin
      wr(4'd0, mk(1, 0, 2, 3, 0, 0, codes_c[k], codes_s[k], 1));
      wr(4'd6, 32'd0);
      ncpu = 0; nsys = 0;
      repeat (600) begin
        @(negedge clk);
        if (cpu_rst_o) ncpu++;
        if (sys_rst_o) nsys++;
      end
      chk("R9 cpu pulse width", ncpu, exp_cycles(codes_c[k]));
      chk("R9 sys pulse width", nsys, exp_cycles(codes_s[k]));
      wr(4'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 1));
    end

    // R6 / R7 order and wrap: silent stages 0..2, cpu on stage 3
    wr(4'd2, 32'd5); wr(4'd3, 32'd6); wr(4'd4, 32'd7); wr(4'd5, 32'd8);
    wr(4'd0, mk(1, 0, 0, 0, 0, 2, 0, 0, 1));
    wr(4'd6, 32'd0);
    wait_rise_cpu(n);
    chk("R6 R7 first action after all stages", n, 26);
    n = 0;
    while (cpu_rst_o && n < 5000) begin @(negedge clk); n++; end
    while (!cpu_rst_o && n < 5000) begin @(negedge clk); n++; end
    chk("R6 wrap period", n, 26);
    wr(4'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 1));

    // R8 feed holds off timeout
    wr(4'd10, 32'd1);
    wr(4'd2, 32'd8); wr(4'd3, 32'd1000); wr(4'd4, 32'd1000); wr(4'd5, 32'd1000);
    wr(4'd0, mk(1, 0, 1, 0, 0, 0, 0, 0, 1));
    for (int k = 0; k < 10; k++) begin
      wr(4'd6, 32'd0);
      repeat (3) @(negedge clk);
    end
    chk("R8 repeated feed prevents timeout", irq_o, 0);
    wr(4'd6, 32'hFFFF_FFFF);
    n = 0;
    while (!irq_o && n < 1000) begin @(negedge clk); n++; end
    chk("R8 count restarts from feed", n, 8);

    // R10 boot arm alone
    wr(4'd0, mk(0, 1, 3, 0, 0, 0, 0, 0, 1));
    wr(4'd6, 32'd0);
    n = 0;
    while (!sys_rst_o && n < 1000) begin @(negedge clk); n++; end
    chk("R10 boot arm times out with run clear", n, 8);
    wr(4'd0, mk(0, 0, 3, 0, 0, 0, 0, 0, 1));
    repeat (20) @(negedge clk);
    nsys = 0;
    repeat (60) begin @(negedge clk); if (sys_rst_o) nsys++; end
    chk("R10 disarmed stays quiet", nsys, 0);

    // R2 lock blocks control and feed
    wr(4'd7, 32'd0);
    wr(4'd0, mk(1, 0, 1, 0, 0, 0, 0, 0, 1));
    rd(4'd0, d); chk("R2 locked ctrl unchanged", d, mk(0, 0, 3, 0, 0, 0, 0, 0, 0));
    wr(4'd10, 32'd1);
    rd(4'd9, d); chk("R2 locked clear ignored", d, 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule